// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Device Reset Instruction

This block is the serial test port of a small device. A four-wire serial interface (test clock, mode select, data in, data out) drives a 16-state test-port state machine. That state machine moves shift data through a 4-bit instruction register and through one of four data registers: a one-bit bypass stage, a 32-bit identification word, a one-bit reset register, and a boundary chain over a parameterised set of bidirectional pins. The boundary chain sits between the core's pin signals and the pads. It can sample the pads, preload safe values, and take over the pads for board interconnect tests.

A public reset instruction selects the one-bit reset register. While that instruction is active and the bit is set, the system reset output is asserted. An external reset input produces the same reset. Whenever the system reset is asserted and the pads are not under test control, every pad output enable is forced low at once, so no separate high-impedance instruction is needed. The port works only when an enable fuse is programmed and a software disable bit is clear. All scan logic runs on the test clock alone.

Top module: `tapsc_top`

## Requirements
- R1: The state machine follows the standard 16-state graph, with `tms` sampled on the rising edge of `tck`. Five consecutive cycles with `tms`=1 reach Test-Logic-Reset from any state.
- R2: The instruction register is 4 bits wide. Capture-IR loads 4'b0001. Shift-IR shifts with the LSB out first and `tdi` entering the MSB. The new code takes effect on the rising edge that leaves Update-IR. Test-Logic-Reset selects the identification instruction.
- R3: The instruction codes are 0x0 for external test, 0x1 for identification, 0x2 for sample/preload, 0xC for device reset and 0xF for bypass. Every other code behaves as bypass.
- R4: Under the identification instruction, Capture-DR loads the 32-bit device ID, which is shifted out LSB first. Bit 0 is always 1, whatever the parameter holds. This is the first data-register scan after Test-Logic-Reset.
- R5: Under bypass, the data path is a single stage that captures 0. Each `tdi` bit appears on `tdo` one shift later.
- R6: The boundary chain has 3 cells per pin. Pin i uses cell 3i for the pad input, 3i+1 for the output enable and 3i+2 for the output value, and cell 0 is nearest `tdo`. Under sample/preload, Capture-DR loads `pad_in`, `core_oe` and `core_out` into these cells, while the pads and `core_in` keep following the core.
- R7: Update-DR under sample/preload or external test copies the chain into the update latches. Under external test, `pad_out`, `pad_oe` and `core_in` come from these latches. This takes effect as soon as the instruction is updated.
- R8: Under the device reset instruction, the one-bit reset register captures its current value and is updated on Update-DR. `sys_rst` is high while the instruction is active and the bit is 1. The bit clears in Test-Logic-Reset.
- R9: `ext_rst` asserts `sys_rst` combinationally. Outside external test, a high `sys_rst` drives every `pad_oe` bit to 0 in the same cycle.
- R10: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only in Shift-IR and Shift-DR.
- R11: The port is enabled only when `fuse_en`=1 and `sw_dis`=0. When it is disabled, the state machine is held in Test-Logic-Reset, `tdo_oe` stays 0 and the pads follow the core.
- R12: The synchronous active-high `rst` puts the port in Test-Logic-Reset with the identification instruction, clears the reset bit and the update latches, and drives `tdo_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled on `tck` |
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| fuse_en | input | 1 | Enable fuse, 1 when programmed |
| sw_dis | input | 1 | Software disable bit for the test port |
| ext_rst | input | 1 | External device reset request, active high |
| sys_rst | output | 1 | System reset to the core, active high |
| core_out | input | NPINS | Output values from the core |
| core_oe | input | NPINS | Output enables from the core |
| core_in | output | NPINS | Pin input values delivered to the core |
| pad_out | output | NPINS | Output values to the pads |
| pad_oe | output | NPINS | Output enables to the pads |
| pad_in | input | NPINS | Values received at the pads |

## Verification
The bench targets four kinds of fault. First, it checks the first data scan after a reset. A design with the wrong default instruction or an unforced ID bit 0 would shift out the wrong word. Second, it checks the moment external test takes over the pads. If the update latches were missing or the chain order were wrong, stale or shuffled values would appear on the pads right after the instruction update. Third, it drives the reset register both ways and drives the external reset, and checks that output enables drop in the same cycle and that the reset register reads back its previous value. A wrong-edge or missing clear would show up here. Last, it checks the enable gating and the falling-edge timing of `tdo` on every clock: a port that ignored the fuse or the disable bit, or that moved `tdo` on the rising edge, would drive the test data line when it should not.

// File: rtl/tapsc_pkg.sv
package tapsc_pkg;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'h0;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'h1;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'h2;
  localparam logic [IR_W-1:0] OP_RSTREG = 4'hC;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE, TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR,
    TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR, TS_SEL_IR, TS_CAP_IR,
    TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {
    SEL_BYPASS, SEL_IDCODE, SEL_BSCAN, SEL_RSTREG
  } dr_sel_t;

  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    tap_state_t n;
    case (s)
      TS_RESET:    n = m ? TS_RESET    : TS_IDLE;
      TS_IDLE:     n = m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   n = m ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   n = m ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: n = m ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: n = m ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: n = m ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: n = m ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   n = m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   n = m ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   n = m ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: n = m ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: n = m ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: n = m ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: n = m ? TS_UPD_IR   : TS_SHIFT_IR;
      TS_UPD_IR:   n = m ? TS_SEL_DR   : TS_IDLE;
      default:     n = TS_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tapsc_fsm.sv
module tapsc_fsm
  import tapsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tms,
  output tap_state_t state
);

  always_ff @(posedge clk) begin
    if (rst || !en) state <= TS_RESET;
    else            state <= tap_next(state, tms);
  end

  // R1: leaving Select-IR with tms high returns to Test-Logic-Reset
  a_r1_sel_ir_escape: assert property (@(posedge clk) disable iff (rst)
    (en && tms && state == TS_SEL_IR) |=> state == TS_RESET);

  // R1: Shift-DR holds while tms is low
  a_r1_shift_hold: assert property (@(posedge clk) disable iff (rst)
    (en && !tms && state == TS_SHIFT_DR) |=> state == TS_SHIFT_DR);

endmodule

// File: rtl/tapsc_ir.sv
module tapsc_ir
  import tapsc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic            ir_lsb,
  output dr_sel_t         dr_sel,
  output logic            mode_extest,
  output logic            mode_rst
);

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_sr <= '0;
      ir_q  <= OP_IDCODE;
    end else begin
      case (state)
        TS_CAP_IR:   ir_sr <= IR_CAPTURE;
        TS_SHIFT_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        default:     ;
      endcase
      if (state == TS_RESET)       ir_q <= OP_IDCODE;
      else if (state == TS_UPD_IR) ir_q <= ir_sr;
    end
  end

  assign ir_lsb = ir_sr[0];

  always_comb begin
    dr_sel      = SEL_BYPASS;
    mode_extest = 1'b0;
    mode_rst    = 1'b0;
    case (ir_q)
      OP_EXTEST: begin dr_sel = SEL_BSCAN; mode_extest = 1'b1; end
      OP_IDCODE: dr_sel = SEL_IDCODE;
      OP_SAMPLE: dr_sel = SEL_BSCAN;
      OP_RSTREG: begin dr_sel = SEL_RSTREG; mode_rst = 1'b1; end
      default:   dr_sel = SEL_BYPASS;
    endcase
  end

  // R2: capture loads the fixed pattern
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    state == TS_CAP_IR |=> ir_sr == IR_CAPTURE);

  // R2: the active instruction only moves on Update-IR or in reset state
  a_r2_ir_stable: assert property (@(posedge clk) disable iff (rst)
    (state != TS_UPD_IR && state != TS_RESET) |=> $stable(ir_q));

endmodule

// File: rtl/tapsc_dr.sv
module tapsc_dr
  import tapsc_pkg::*;
#(
  parameter int          NPINS  = 8,
  parameter logic [31:0] DEV_ID = 32'h0000_0001,
  localparam int         CHAIN  = 3 * NPINS
) (
  input  logic             clk,
  input  logic             rst,
  input  tap_state_t       state,
  input  dr_sel_t          dr_sel,
  input  logic             tdi,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  output logic             dr_lsb,
  output logic [CHAIN-1:0] bs_upd,
  output logic             rst_bit
);

  localparam logic [31:0] ID_WORD = DEV_ID | 32'h1;

  logic             byp;
  logic [31:0]      id_sr;
  logic             rb_sr;
  logic [CHAIN-1:0] bs_sr;
  logic [CHAIN-1:0] bs_cap;

  for (genvar i = 0; i < NPINS; i++) begin : g_cap
    assign bs_cap[3*i]   = pad_in[i];
    assign bs_cap[3*i+1] = core_oe[i];
    assign bs_cap[3*i+2] = core_out[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp     <= 1'b0;
      id_sr   <= '0;
      rb_sr   <= 1'b0;
      rst_bit <= 1'b0;
      bs_sr   <= '0;
      bs_upd  <= '0;
    end else begin
      case (state)
        TS_RESET: rst_bit <= 1'b0;
        TS_CAP_DR: begin
          case (dr_sel)
            SEL_BYPASS: byp   <= 1'b0;
            SEL_IDCODE: id_sr <= ID_WORD;
            SEL_BSCAN:  bs_sr <= bs_cap;
            SEL_RSTREG: rb_sr <= rst_bit;
            default:    ;
          endcase
        end
        TS_SHIFT_DR: begin
          case (dr_sel)
            SEL_BYPASS: byp   <= tdi;
            SEL_IDCODE: id_sr <= {tdi, id_sr[31:1]};
            SEL_BSCAN:  bs_sr <= {tdi, bs_sr[CHAIN-1:1]};
            SEL_RSTREG: rb_sr <= tdi;
            default:    ;
          endcase
        end
        TS_UPD_DR: begin
          if (dr_sel == SEL_BSCAN)  bs_upd  <= bs_sr;
          if (dr_sel == SEL_RSTREG) rst_bit <= rb_sr;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (dr_sel)
      SEL_IDCODE: dr_lsb = id_sr[0];
      SEL_BSCAN:  dr_lsb = bs_sr[0];
      SEL_RSTREG: dr_lsb = rb_sr;
      default:    dr_lsb = byp;
    endcase
  end

  // R5: bypass stage captures zero
  a_r5_byp_capture: assert property (@(posedge clk) disable iff (rst)
    (state == TS_CAP_DR && dr_sel == SEL_BYPASS) |=> !byp);

  // R4: captured ID always has bit 0 set
  a_r4_id_bit0: assert property (@(posedge clk) disable iff (rst)
    (state == TS_CAP_DR && dr_sel == SEL_IDCODE) |=> id_sr[0]);

  // R7: update latches change only on Update-DR
  a_r7_upd_hold: assert property (@(posedge clk) disable iff (rst)
    state != TS_UPD_DR |=> $stable(bs_upd));

  // R8: reset bit clears in Test-Logic-Reset
  a_r8_rb_clear: assert property (@(posedge clk) disable iff (rst)
    state == TS_RESET |=> !rst_bit);

endmodule

// File: rtl/tapsc_top.sv
module tapsc_top
  import tapsc_pkg::*;
#(
  parameter int          NPINS  = 8,
  parameter logic [31:0] DEV_ID = 32'h1A5C_3E4B
) (
  input  logic             rst,
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic             fuse_en,
  input  logic             sw_dis,
  input  logic             ext_rst,
  output logic             sys_rst,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  output logic [NPINS-1:0] core_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  input  logic [NPINS-1:0] pad_in
);

  localparam int CHAIN = 3 * NPINS;

  tap_state_t       state;
  dr_sel_t          dr_sel;
  logic             tap_en;
  logic             ir_lsb;
  logic             dr_lsb;
  logic             mode_extest;
  logic             mode_rst;
  logic             rst_bit;
  logic [CHAIN-1:0] bs_upd;

  assign tap_en = fuse_en & ~sw_dis;

  tapsc_fsm u_fsm (
    .clk(tck), .rst(rst), .en(tap_en), .tms(tms), .state(state)
  );

  tapsc_ir u_ir (
    .clk(tck), .rst(rst), .state(state), .tdi(tdi), .ir_lsb(ir_lsb),
    .dr_sel(dr_sel), .mode_extest(mode_extest), .mode_rst(mode_rst)
  );

  tapsc_dr #(.NPINS(NPINS), .DEV_ID(DEV_ID)) u_dr (
    .clk(tck), .rst(rst), .state(state), .dr_sel(dr_sel), .tdi(tdi),
    .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
    .dr_lsb(dr_lsb), .bs_upd(bs_upd), .rst_bit(rst_bit)
  );

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      case (state)
        TS_SHIFT_IR: begin tdo <= ir_lsb; tdo_oe <= 1'b1; end
        TS_SHIFT_DR: begin tdo <= dr_lsb; tdo_oe <= 1'b1; end
        default:     tdo_oe <= 1'b0;
      endcase
    end
  end

  assign sys_rst = ext_rst | (mode_rst & rst_bit);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pad_out[i] = mode_extest ? bs_upd[3*i+2] : core_out[i];
    assign pad_oe[i]  = mode_extest ? bs_upd[3*i+1] : (core_oe[i] & ~sys_rst);
    assign core_in[i] = mode_extest ? bs_upd[3*i]   : pad_in[i];
  end

  // R9: reset outside external test leaves all pads undriven
  a_r9_reset_hiz: assert property (@(posedge tck) disable iff (rst)
    (sys_rst && !mode_extest) |-> pad_oe == '0);

  // R10: tdo is only enabled in the two shift states
  a_r10_oe_shift: assert property (@(posedge tck) disable iff (rst)
    tdo_oe |-> (state == TS_SHIFT_IR || state == TS_SHIFT_DR));

  // R11: a disabled port never drives tdo
  a_r11_disabled: assert property (@(posedge tck) disable iff (rst)
    (!tap_en && $past(!tap_en)) |-> !tdo_oe);

endmodule

// File: tb/tapsc_top_tb_top.sv
`timescale 1ns/1ps
module tapsc_top_tb_top;

  localparam int NP = 8;
  localparam logic [31:0] ID_PARAM = 32'h2B6A_1C34;
  localparam logic [31:0] ID_EXP   = 32'h2B6A_1C35;

  logic rst = 1'b1, tck = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic fuse_en = 1'b1, sw_dis = 1'b0, ext_rst = 1'b0;
  logic [NP-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic tdo, tdo_oe, sys_rst;
  logic [NP-1:0] core_in, pad_out, pad_oe;

  int checks = 0;
  int errors = 0;

  // reference model
  int m_state = 0;
  int m_ir = 1;
  int m_irsh = 0;
  int m_rb = 0;
  int m_rbsh = 0;

  always #2.5 tck = ~tck;

  tapsc_top #(.NPINS(NP), .DEV_ID(ID_PARAM)) dut_i (
    .rst(rst), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .fuse_en(fuse_en), .sw_dis(sw_dis), .ext_rst(ext_rst), .sys_rst(sys_rst),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int s, input bit m);
    case (s)
      0: return m ? 0 : 1;
      1: return m ? 2 : 1;
      2: return m ? 9 : 3;
      3: return m ? 5 : 4;
      4: return m ? 5 : 4;
      5: return m ? 8 : 6;
      6: return m ? 7 : 6;
      7: return m ? 8 : 4;
      8: return m ? 2 : 1;
      9: return m ? 0 : 10;
      10: return m ? 12 : 11;
      11: return m ? 12 : 11;
      12: return m ? 15 : 13;
      13: return m ? 14 : 13;
      14: return m ? 15 : 11;
      default: return m ? 2 : 1;
    endcase
  endfunction

  function automatic void model_step(input bit m, input bit d);
    if (rst) begin
      m_state = 0; m_ir = 1; m_rb = 0; m_irsh = 0; m_rbsh = 0;
      return;
    end
    if (!(fuse_en && !sw_dis)) begin
      m_state = 0;
      return;
    end
    case (m_state)
      0: begin m_ir = 1; m_rb = 0; end
      10: m_irsh = 1;
      11: m_irsh = (m_irsh >> 1) | (int'(d) << 3);
      15: m_ir = m_irsh;
      3: if (m_ir == 12) m_rbsh = m_rb;
      4: if (m_ir == 12) m_rbsh = int'(d);
      8: if (m_ir == 12) m_rb = m_rbsh;
      default: ;
    endcase
    m_state = nxt(m_state, m);
  endfunction

  // One test clock; called at falling edge + 1 ns, returns at the next one.
  task automatic clk1(input bit m, input bit d);
    logic o_tdo, o_oe, exp_sr;
    tms = m; tdi = d;
    o_tdo = tdo; o_oe = tdo_oe;
    model_step(m, d);
    @(posedge tck); #1;
    chk(tdo === o_tdo && tdo_oe === o_oe, "R10 tdo moved on rising edge",
        {o_oe, o_tdo}, {tdo_oe, tdo});
    @(negedge tck); #1;
    chk(tdo_oe === ((m_state == 4 || m_state == 11) ? 1'b1 : 1'b0),
        "R10 tdo_oe per state", tdo_oe, (m_state == 4 || m_state == 11));
    exp_sr = ext_rst | (m_ir == 12 && m_rb != 0);
    chk(sys_rst === exp_sr, "R8 sys_rst model", sys_rst, exp_sr);
    if (m_ir != 0)
      chk(pad_oe === (core_oe & {NP{~exp_sr}}), "R9 pad_oe functional", pad_oe,
          core_oe & {NP{~exp_sr}});
  endtask

  task automatic goto_idle();
    for (int i = 0; i < 5; i++) clk1(1'b1, 1'b0);
    clk1(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [3:0] code, output logic [3:0] cap);
    clk1(1, 0); clk1(1, 0); clk1(0, 0); clk1(0, 0);
    for (int i = 0; i < 4; i++) begin
      cap[i] = tdo;
      clk1(i == 3, code[i]);
    end
    clk1(1, 0); clk1(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    clk1(1, 0); clk1(0, 0); clk1(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      clk1(i == n - 1, din[i]);
    end
    clk1(1, 0); clk1(0, 0);
  endtask

  function automatic logic [63:0] chain_of(input logic [NP-1:0] pi, input logic [NP-1:0] oe,
                                           input logic [NP-1:0] ov);
    logic [63:0] r = '0;
    for (int i = 0; i < NP; i++) begin
      r[3*i] = pi[i]; r[3*i+1] = oe[i]; r[3*i+2] = ov[i];
    end
    return r;
  endfunction

  initial begin : watchdog
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [3:0] cap;
    logic [63:0] dout, p1, p2, ex;
    @(negedge tck); #1;
    for (int i = 0; i < 4; i++) clk1(1, 0);
    rst = 1'b0;
    // R12 reset state
    chk(tdo_oe === 1'b0, "R12 tdo_oe after reset", tdo_oe, 0);
    chk(sys_rst === 1'b0, "R12 sys_rst after reset", sys_rst, 0);
    core_out = 8'h69; core_oe = 8'hC3; pad_in = 8'h1E;
    #0.5;
    chk(pad_out === core_out && pad_oe === core_oe, "R12 pads follow core", {pad_out, pad_oe},
        {core_out, core_oe});

    // R4 identification first after reset
    clk1(0, 0);
    scan_dr(32, 64'h0, dout);
    chk(dout[31:0] === ID_EXP, "R4 id word with bit0 forced", dout[31:0], ID_EXP);

    // R2 capture pattern and R5 bypass
    load_ir(4'hF, cap);
    chk(cap === 4'b0001, "R2 IR capture", cap, 4'b0001);
    scan_dr(8, 64'hB2, dout);
    chk(dout[7:0] === 8'h64, "R5 bypass delay", dout[7:0], 8'h64);

    // R3 unused code behaves as bypass
    load_ir(4'h7, cap);
    scan_dr(8, 64'h5D, dout);
    chk(dout[7:0] === 8'hBA, "R3 unused code is bypass", dout[7:0], 8'hBA);

    // R6 sample/preload
    load_ir(4'h2, cap);
    pad_in = 8'hA5; core_out = 8'h3C; core_oe = 8'hF0;
    p1 = 64'h00_9A_C3_5E;
    scan_dr(3 * NP, p1, dout);
    ex = chain_of(8'hA5, 8'hF0, 8'h3C);
    chk(dout[23:0] === ex[23:0], "R6 sample capture order", dout[23:0], ex[23:0]);
    chk(pad_out === core_out && pad_oe === core_oe && core_in === pad_in,
        "R6 sample leaves pads with core", {pad_out, pad_oe, core_in},
        {core_out, core_oe, pad_in});

    // R7 external test takes effect at instruction update
    load_ir(4'h0, cap);
    for (int i = 0; i < NP; i++) begin
      chk(pad_out[i] === p1[3*i+2] && pad_oe[i] === p1[3*i+1] && core_in[i] === p1[3*i],
          "R7 extest pads from preload", {pad_out[i], pad_oe[i], core_in[i]},
          {p1[3*i+2], p1[3*i+1], p1[3*i]});
    end
    pad_in = 8'h5A;
    p2 = 64'h00_47_1B_E6;
    scan_dr(3 * NP, p2, dout);
    ex = chain_of(8'h5A, 8'hF0, 8'h3C);
    chk(dout[23:0] === ex[23:0], "R7 extest capture", dout[23:0], ex[23:0]);
    for (int i = 0; i < NP; i++)
      chk(pad_out[i] === p2[3*i+2] && pad_oe[i] === p2[3*i+1],
          "R7 extest update", {pad_out[i], pad_oe[i]}, {p2[3*i+2], p2[3*i+1]});

    // R8 reset instruction
    load_ir(4'hC, cap);
    chk(pad_out === core_out, "R8 pads back to core", pad_out, core_out);
    scan_dr(1, 64'h1, dout);
    chk(dout[0] === 1'b0, "R8 reset bit capture initial", dout[0], 0);
    chk(sys_rst === 1'b1 && pad_oe === '0, "R8 reset held with hiz", {sys_rst, pad_oe}, 9'h100);
    scan_dr(1, 64'h0, dout);
    chk(dout[0] === 1'b1, "R8 reset bit capture set", dout[0], 1);
    chk(sys_rst === 1'b0, "R8 reset released", sys_rst, 0);
    scan_dr(1, 64'h1, dout);
    load_ir(4'hF, cap);
    chk(sys_rst === 1'b0, "R8 leaving instruction releases reset", sys_rst, 0);

    // R9 external reset
    ext_rst = 1'b1; #0.5;
    chk(sys_rst === 1'b1 && pad_oe === '0, "R9 ext reset hiz", {sys_rst, pad_oe}, 9'h100);
    clk1(0, 0);
    ext_rst = 1'b0; #0.5;
    chk(pad_oe === core_oe, "R9 ext reset release", pad_oe, core_oe);

    // R1 five tms ones return to reset and identification
    goto_idle();
    scan_dr(32, 64'h0, dout);
    chk(dout[31:0] === ID_EXP, "R1 tms reset restores id", dout[31:0], ID_EXP);

    // R11 disabled by fuse, then by software bit
    fuse_en = 1'b0;
    clk1(1, 0); clk1(0, 0); clk1(0, 0); clk1(0, 1); clk1(0, 1);
    chk(tdo_oe === 1'b0, "R11 fuse off tdo idle", tdo_oe, 0);
    chk(pad_out === core_out && core_in === pad_in, "R11 fuse off pads follow core",
        {pad_out, core_in}, {core_out, pad_in});
    fuse_en = 1'b1; sw_dis = 1'b1;
    clk1(0, 0); clk1(1, 0); clk1(0, 0); clk1(0, 0); clk1(0, 1);
    chk(tdo_oe === 1'b0, "R11 sw disable tdo idle", tdo_oe, 0);
    sw_dis = 1'b0;
    clk1(0, 0);
    scan_dr(32, 64'h0, dout);
    chk(dout[31:0] === ID_EXP, "R11 re-enabled reads id", dout[31:0], ID_EXP);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule